// File: doc/BRIEF.md
# Transmit Jabber Lockout Timer

This block sits between a repeater's transmit request and its line driver and stops a runaway transmission. It counts bit times while the transmit request stays asserted. When a transmission has run continuously past a fixed limit, the block forces its gated transmit-enable low for a fixed quiet interval. After that interval it lets the transmitter run again. This works with no software action.

Both counters advance only on a one-cycle bit-time tick, so the block runs from any core clock that is faster than the bit rate. Each lockup also sets a sticky status flag. A management reader samples this flag and clears it with a one-cycle clear pulse. If a lockup begins in the same cycle as a clear, the flag stays set, so no lockup is lost.

Top module: `jabber_guard`

## Requirements
- R1: Outside a lockup, `tx_en_out` equals `tx_req` in the same cycle.
- R2: Suppose `tx_req` was high at RUN_LIMIT consecutive ticks (`bit_tick`=1) since the count was last cleared, and it is high again at the next tick. From the cycle after that tick, `lockup_active` is 1 and `tx_en_out` is 0.
- R3: A lockup lasts exactly QUIET_LEN ticks. Throughout that time `tx_en_out` stays 0, whatever `tx_req` does.
- R4: When the quiet interval ends, a `tx_req` that is still high passes straight through again and starts a fresh count. A lockup follows after RUN_LIMIT+1 further ticks.
- R5: A tick at which `tx_req` is low clears the continuous-transmit count.
- R6: Both counters hold their value in any cycle where `bit_tick` is 0.
- R7: `jabber_stat` becomes 1 in the cycle after a lockup begins. It stays 1, across the end of the lockup, until a clear.
- R8: A `stat_clr` pulse makes `jabber_stat` 0 from the next cycle. If a lockup begins in the same cycle as the clear, the flag stays 1.
- R9: After reset, `lockup_active` and `jabber_stat` are 0 and the block is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_req | input | 1 | Requested transmit-enable |
| stat_clr | input | 1 | Clear pulse for the status flag from the management side |
| tx_en_out | output | 1 | Gated transmit-enable to the driver |
| lockup_active | output | 1 | High while the forced quiet interval runs |
| jabber_stat | output | 1 | Sticky lockup status flag |

## Verification
Some properties are checked by assertions on every cycle:
- The gated enable never rises without a request.
- A limit overrun always enters the lockup on the next cycle.
- Neither counter goes past its bound.
- The lockup state holds across cycles with no tick.
- The status flag rises with each lockup and falls only after a clear.

Other properties depend on exact tick counts, and only the bench scenarios show them:
- The exact length of the continuous run before a lockup.
- The exact length of the quiet interval.
- The count clearing after a low request.
- The restart of a held request.
- Set winning over clear.

// File: rtl/jabber_pkg.sv
package jabber_pkg;

    localparam int unsigned JAB_RUN_LIMIT_DEF = 65536;
    localparam int unsigned JAB_QUIET_LEN_DEF = 96;

    typedef enum logic {
        JAB_ST_RUN   = 1'b0,
        JAB_ST_QUIET = 1'b1
    } jab_state_e;

    typedef struct packed {
        logic over;
        logic done;
    } jab_evt_t;

    function automatic int unsigned jab_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/jab_run_ctr.sv
module jab_run_ctr #(
    parameter int unsigned RUN_LIMIT = jabber_pkg::JAB_RUN_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  logic hold_clr,
    output logic over
);
    localparam int unsigned CW = jabber_pkg::jab_width(RUN_LIMIT);
    localparam logic [CW-1:0] LIMIT_V = CW'(RUN_LIMIT);

    logic [CW-1:0] run_cnt;

    assign over = tick && req && !hold_clr && (run_cnt == LIMIT_V);

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!req)
                run_cnt <= '0;
            else if (run_cnt != LIMIT_V)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LIMIT_V);

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold_clr) |=> $stable(run_cnt));

    // R5
    run_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !req) |=> (run_cnt == '0));
endmodule

// File: rtl/jab_quiet_tmr.sv
module jab_quiet_tmr #(
    parameter int unsigned QUIET_LEN = jabber_pkg::JAB_QUIET_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    output logic done
);
    localparam int unsigned QW = jabber_pkg::jab_width(QUIET_LEN);
    localparam logic [QW-1:0] LAST_V = QW'(QUIET_LEN - 1);

    logic [QW-1:0] q_cnt;

    assign done = active && tick && (q_cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || !active || done)
            q_cnt <= '0;
        else if (tick)
            q_cnt <= q_cnt + 1'b1;
    end

    // R3
    quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_cnt <= LAST_V);

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> $stable(q_cnt));
endmodule

// File: rtl/jab_status.sv
module jab_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R7
    stat_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R7
    stat_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
    parameter int unsigned RUN_LIMIT = jabber_pkg::JAB_RUN_LIMIT_DEF,
    parameter int unsigned QUIET_LEN = jabber_pkg::JAB_QUIET_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic stat_clr,
    output logic tx_en_out,
    output logic lockup_active,
    output logic jabber_stat
);
    import jabber_pkg::*;

    jab_state_e state_q;
    jab_evt_t   evt;
    logic       in_quiet;

    assign in_quiet = (state_q == JAB_ST_QUIET);

    jab_run_ctr #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .req      (tx_req),
        .hold_clr (in_quiet),
        .over     (evt.over)
    );

    jab_quiet_tmr #(.QUIET_LEN(QUIET_LEN)) u_quiet (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .active (in_quiet),
        .done   (evt.done)
    );

    jab_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .set  (evt.over),
        .clr  (stat_clr),
        .flag (jabber_stat)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= JAB_ST_RUN;
        else if (!in_quiet && evt.over)
            state_q <= JAB_ST_QUIET;
        else if (in_quiet && evt.done)
            state_q <= JAB_ST_RUN;
    end

    assign lockup_active = in_quiet;
    assign tx_en_out     = tx_req && !in_quiet;

    // R2
    over_enter_chk: assert property (@(posedge clk) disable iff (rst)
        evt.over |=> lockup_active);

    // R1
    no_spurious_en_chk: assert property (@(posedge clk) disable iff (rst)
        tx_en_out |-> tx_req);

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(lockup_active));

    // R7
    lock_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lockup_active) |-> jabber_stat);
endmodule

// File: tb/jabber_guard_test.sv
module jabber_guard_test;
    localparam int LIM = 40;
    localparam int QL  = 6;

    logic clk = 1'b0;
    logic rst, bit_tick, tx_req, stat_clr;
    logic tx_en_out, lockup_active, jabber_stat;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    jabber_guard #(.RUN_LIMIT(LIM), .QUIET_LEN(QL)) uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_req(tx_req),
        .stat_clr(stat_clr), .tx_en_out(tx_en_out),
        .lockup_active(lockup_active), .jabber_stat(jabber_stat)
    );

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n, input bit tk);
        for (int i = 0; i < n; i++) begin
            bit_tick = tk;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic recover();
        tx_req = 1'b0;
        cyc(QL + 2, 1'b1);
    endtask

    task automatic t_reset();
        chk(lockup_active, 1'b0, "R9 lockup after reset");
        chk(jabber_stat, 1'b0, "R9 status after reset");
        chk(tx_en_out, 1'b0, "R9 enable after reset");
        tx_req = 1'b1; #1;
        chk(tx_en_out, 1'b1, "R1 passthrough high");
        tx_req = 1'b0; #1;
        chk(tx_en_out, 1'b0, "R1 passthrough low");
    endtask

    task automatic t_lock_and_quiet();
        tx_req = 1'b1;
        cyc(LIM, 1'b1);
        chk(tx_en_out, 1'b1, "R2 still enabled at limit");
        chk(lockup_active, 1'b0, "R2 not locked at limit");
        cyc(1, 1'b1);
        chk(lockup_active, 1'b1, "R2 locked after limit+1");
        chk(tx_en_out, 1'b0, "R2 enable cut");
        chk(jabber_stat, 1'b1, "R7 status set");
        cyc(5, 1'b0);
        chk(lockup_active, 1'b1, "R6 quiet holds without tick");
        cyc(QL - 1, 1'b1);
        chk(lockup_active, 1'b1, "R3 quiet at QL-1 ticks");
        chk(tx_en_out, 1'b0, "R3 enable held low");
        cyc(1, 1'b1);
        chk(lockup_active, 1'b0, "R3 quiet ends after QL ticks");
        chk(tx_en_out, 1'b1, "R4 held request resumes");
        cyc(LIM, 1'b1);
        chk(lockup_active, 1'b0, "R4 fresh count not locked");
        cyc(1, 1'b1);
        chk(lockup_active, 1'b1, "R4 locks again after fresh count");
        recover();
        chk(jabber_stat, 1'b1, "R7 status sticky after recovery");
    endtask

    task automatic t_gap_reset();
        tx_req = 1'b1;
        cyc(LIM, 1'b1);
        tx_req = 1'b0;
        cyc(1, 1'b1);
        tx_req = 1'b1;
        cyc(LIM, 1'b1);
        chk(lockup_active, 1'b0, "R5 gap cleared count");
        chk(tx_en_out, 1'b1, "R5 still enabled");
        cyc(1, 1'b1);
        chk(lockup_active, 1'b1, "R5 locks after full new run");
        recover();
    endtask

    task automatic t_tick_only();
        tx_req = 1'b1;
        cyc(3 * LIM, 1'b0);
        chk(lockup_active, 1'b0, "R6 no count without tick");
        for (int i = 0; i < LIM; i++) begin
            cyc(1, 1'b1);
            cyc(2, 1'b0);
        end
        chk(lockup_active, 1'b0, "R6 sparse ticks reach limit only");
        cyc(1, 1'b1);
        chk(lockup_active, 1'b1, "R6 sparse ticks lock on next tick");
        recover();
    endtask

    task automatic t_status();
        stat_clr = 1'b1;
        cyc(1, 1'b0);
        stat_clr = 1'b0;
        chk(jabber_stat, 1'b0, "R8 clear drops status");
        stat_clr = 1'b1;
        cyc(1, 1'b0);
        stat_clr = 1'b0;
        chk(jabber_stat, 1'b0, "R8 clear with no lock stays low");
        tx_req = 1'b1;
        cyc(LIM, 1'b1);
        stat_clr = 1'b1;
        cyc(1, 1'b1);
        stat_clr = 1'b0;
        chk(lockup_active, 1'b1, "R8 lock during clear");
        chk(jabber_stat, 1'b1, "R8 set wins over clear");
        recover();
    endtask

    initial begin
        rst = 1'b1; bit_tick = 1'b0; tx_req = 1'b0; stat_clr = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock_and_quiet();
        t_gap_reset();
        t_tick_only();
        t_status();
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule